// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block sits between a bus and an external successive-approximation converter core. Software selects any subset of eight analog channels in a control word. Conversions begin in one of three ways: a software start, an edge of chosen polarity on one of six trigger inputs, or a free-running burst that walks the selected channels. The block talks to the converter with a start pulse, a busy level and a done pulse that carries a 12-bit result. It also produces a clock-enable strobe for the converter by dividing the bus clock.

Each channel has its own result word, and a global result word holds the latest conversion. Both carry a done flag and an overrun flag. Reading a result word clears its flags. A status word collects all per-channel flags and the interrupt line, and an enable word chooses which done flags raise that line. Bus reads are combinational. A flag clear happens on the clock edge that ends the read cycle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `conv_start` is low.
- R2: While the power bit (control bit 21) is set, `conv_clk_en` pulses once every DIV+1 bus cycles, where DIV is control bits [15:8]. While the power bit is clear, `conv_clk_en` stays low.
- R3: Writing 1 to the start field (control bits [26:24]) launches one conversion of the lowest-index channel selected in control bits [7:0]. `conv_start` is a one-cycle pulse. The start field reads back as 0 once the conversion has launched.
- R4: A result word has this layout: result in bits [15:4], channel number in bits [26:24], overrun in bit 30, done in bit 31, and zero everywhere else. The per-channel word for channel n is at word address 8+n, and the global word is at address 1.
- R5: A completed conversion sets the done flag of its channel word and of the global word. Reading a word clears that word's own flags and no others.
- R6: A start field of 2 to 7 arms a conversion on an edge of `trig_in[field-2]`. Control bit 27 = 0 selects the rising edge and 1 selects the falling edge. An edge of the other polarity starts nothing.
- R7: With burst (control bit 16) set, conversions repeat with no software start. They visit the selected channels in ascending index order and wrap to the lowest selected channel.
- R8: A result that arrives in burst mode while its word's done flag is still set sets that word's overrun flag. A result that arrives outside burst mode does not. The status word (address 3) mirrors done in bits [7:0] and overrun in bits [15:8].
- R9: The enable word (address 2) has per-channel enables in bits [7:0] and a global-done enable in bit 8. `irq` is high when any enabled done flag is set, and status bit 16 reads the same value.
- R10: While the power bit is clear, no conversion starts, and a pending start-now request stays in the start field.
- R11: `conv_start` is never asserted in the cycle after `conv_busy` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flags of the addressed result word) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| trig_in | input | 6 | External trigger inputs |
| conv_clk_en | output | 1 | Converter clock-enable strobe |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 3 | Channel for the conversion being started |
| conv_busy | input | 1 | Converter busy level |
| conv_done | input | 1 | Converter done pulse, result valid |
| conv_result | input | 12 | Converter result |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on three assumptions about the inputs. The divider value stays constant while the divider runs. `conv_done` arrives only for a conversion that was actually started. `conv_busy` rises no later than the cycle after `conv_start`. The bench's converter model meets these conditions: it raises busy on the edge that samples the start, and it answers with exactly one done pulse per start. The bench changes the control word only when the converter is idle or, in burst mode, when exactly one conversion is in flight.

// File: rtl/adc_seq_pkg.sv
// Shared constants, register addresses and word layouts for the
// conversion sequencer. Assumes eight channels and 12-bit results.
package adc_seq_pkg;
    localparam int NUM_CH   = 8;
    localparam int CH_W     = 3;
    localparam int RES_W    = 12;
    localparam int NUM_TRIG = 6;
    localparam int DIV_W    = 8;
    localparam int DW       = 32;
    localparam int AW       = 4;
    localparam int SEL_W    = 3;

    localparam logic [AW-1:0] REG_CTRL   = 4'd0;
    localparam logic [AW-1:0] REG_GLOBAL = 4'd1;
    localparam logic [AW-1:0] REG_IRQEN  = 4'd2;
    localparam logic [AW-1:0] REG_STATUS = 4'd3;

    localparam logic [SEL_W-1:0] START_OFF = 3'd0;
    localparam logic [SEL_W-1:0] START_NOW = 3'd1;

    typedef struct packed {
        logic             fall_edge;
        logic [SEL_W-1:0] start;
        logic             pwr;
        logic             burst;
        logic [DIV_W-1:0] div;
        logic [NUM_CH-1:0] mask;
    } ctrl_t;

    // Unpack a bus word into control fields.
    function automatic ctrl_t ctrl_from_word(input logic [DW-1:0] w);
        ctrl_t c;
        c.mask      = w[7:0];
        c.div       = w[15:8];
        c.burst     = w[16];
        c.pwr       = w[21];
        c.start     = w[26:24];
        c.fall_edge = w[27];
        return c;
    endfunction

    // Pack control fields back into their bus positions.
    function automatic logic [DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [DW-1:0] w;
        w        = '0;
        w[7:0]   = c.mask;
        w[15:8]  = c.div;
        w[16]    = c.burst;
        w[21]    = c.pwr;
        w[26:24] = c.start;
        w[27]    = c.fall_edge;
        return w;
    endfunction

    // Build a result word from its flags, channel and value.
    function automatic logic [DW-1:0] result_word(input logic done, input logic ovr,
                                                  input logic [CH_W-1:0] ch,
                                                  input logic [RES_W-1:0] r);
        logic [DW-1:0] w;
        w        = '0;
        w[15:4]  = r;
        w[26:24] = ch;
        w[30]    = ovr;
        w[31]    = done;
        return w;
    endfunction
endpackage

// File: rtl/adc_clk_div.sv
// Converter clock-enable generator: with en set, tick pulses once every
// div+1 cycles. Assumes div is held constant while en is set.
module adc_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt >= div);

    // Count bus cycles up to div, restart on each tick or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!en || tick)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/adc_trig_edge.sv
// Trigger edge detector: when sel is 2..NT+1, watches trig[sel-2] for the
// polarity given by fall and raises pend until a launch clears it.
// Assumes trigger inputs are already synchronous to clk.
module adc_trig_edge #(
    parameter int NT    = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    trig,
    input  logic [SEL_W-1:0] sel,
    input  logic             fall,
    input  logic             clear,
    output logic             pend
);
    localparam logic [SEL_W-1:0] FIRST_SEL = SEL_W'(2);

    logic [NT-1:0] prev;
    logic [NT-1:0] rise_v;
    logic [NT-1:0] fall_v;
    logic          hit;

    assign rise_v = trig & ~prev;
    assign fall_v = ~trig & prev;

    // Pick the edge of the selected input with the selected polarity.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (sel == FIRST_SEL + SEL_W'(i))
                hit = fall ? fall_v[i] : rise_v[i];
        end
    end

    // Remember last input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= trig;
    end

    // Hold a request from the edge until the sequencer launches it.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (hit)   pend <= 1'b1;
        else if (clear) pend <= 1'b0;
    end

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clear) |=> pend);
endmodule

// File: rtl/adc_scan_seq.sv
// Conversion sequencer: launches conversions on a clock-enable tick when
// the converter is idle, chooses the channel (lowest selected for single
// starts, next selected in ascending order for burst), and forwards the
// returned result to the result bank. Assumes one conv_done per start.
module adc_scan_seq #(
    parameter int NCH = 8,
    parameter int CHW = 3,
    parameter int RW  = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr,
    input  logic           burst,
    input  logic [NCH-1:0] mask,
    input  logic           single_req,
    input  logic           tick,
    input  logic           conv_busy,
    input  logic           conv_done,
    input  logic [RW-1:0]  conv_result,
    output logic           conv_start,
    output logic [CHW-1:0] conv_chan,
    output logic           launch,
    output logic           wr_en,
    output logic [CHW-1:0] wr_chan,
    output logic [RW-1:0]  wr_data
);
    localparam logic [CHW-1:0] TOP_CH = CHW'(NCH - 1);

    typedef enum logic {SQ_IDLE, SQ_WAIT} sq_t;

    sq_t            state;
    logic [CHW-1:0] last;
    logic [CHW-1:0] pick;

    // First selected channel strictly after cur, wrapping around.
    function automatic logic [CHW-1:0] after(input logic [NCH-1:0] m,
                                             input logic [CHW-1:0] cur);
        logic [CHW-1:0] res;
        logic           found;
        res   = cur;
        found = 1'b0;
        for (int k = 1; k <= NCH; k++) begin
            if (!found && m[(int'(cur) + k) % NCH]) begin
                res   = CHW'((int'(cur) + k) % NCH);
                found = 1'b1;
            end
        end
        return res;
    endfunction

    // Channel choice: resume the scan in burst, else the lowest selected.
    always_comb pick = burst ? after(mask, last) : after(mask, TOP_CH);

    assign launch = (state == SQ_IDLE) && pwr && tick && !conv_busy &&
                    (mask != '0) && (burst || single_req);

    assign wr_en   = (state == SQ_WAIT) && conv_done;
    assign wr_chan = conv_chan;
    assign wr_data = conv_result;

    // Handshake state, start pulse and channel register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            conv_start <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= launch;
            if (launch) begin
                conv_chan <= pick;
                state     <= SQ_WAIT;
            end else if (wr_en) begin
                state <= SQ_IDLE;
            end
        end
    end

    // Scan position: the last burst channel; restarts at the top when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      last <= TOP_CH;
        else if (!burst) last <= TOP_CH;
        else if (launch) last <= pick;
    end

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R10
    pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |=> !conv_start);
    // R11
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> !conv_start);
    // R7
    chan_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (conv_start && $past(mask[pick])));
endmodule

// File: rtl/adc_result_bank.sv
// Result storage: one result word per channel plus a global word, each
// with done and overrun flags. A write sets done; in burst mode a write
// onto a still-set done raises overrun; a read clears the word's flags.
module adc_result_bank #(
    parameter int NCH = 8,
    parameter int CHW = 3,
    parameter int RW  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    burst,
    input  logic                    wr_en,
    input  logic [CHW-1:0]          wr_chan,
    input  logic [RW-1:0]           wr_data,
    input  logic [NCH-1:0]          ch_rd,
    input  logic                    g_rd,
    output logic [NCH-1:0][RW-1:0]  ch_res,
    output logic [NCH-1:0]          ch_done,
    output logic [NCH-1:0]          ch_ovr,
    output logic [RW-1:0]           g_res,
    output logic [CHW-1:0]          g_chan,
    output logic                    g_done,
    output logic                    g_ovr
);
    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            logic hit;
            assign hit = wr_en && (wr_chan == CHW'(gi));

            // Per-channel word: capture on write, clear flags on read.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ch_res[gi]  <= '0;
                    ch_done[gi] <= 1'b0;
                    ch_ovr[gi]  <= 1'b0;
                end else if (hit) begin
                    ch_res[gi]  <= wr_data;
                    ch_done[gi] <= 1'b1;
                    ch_ovr[gi]  <= ch_rd[gi] ? 1'b0
                                   : (ch_ovr[gi] | (burst & ch_done[gi]));
                end else if (ch_rd[gi]) begin
                    ch_done[gi] <= 1'b0;
                    ch_ovr[gi]  <= 1'b0;
                end
            end

            // R5
            rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_rd[gi] && !hit) |=> (!ch_done[gi] && !ch_ovr[gi]));
        end
    endgenerate

    // Global word: follows every write, clears its flags on its own read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_res  <= '0;
            g_chan <= '0;
            g_done <= 1'b0;
            g_ovr  <= 1'b0;
        end else if (wr_en) begin
            g_res  <= wr_data;
            g_chan <= wr_chan;
            g_done <= 1'b1;
            g_ovr  <= g_rd ? 1'b0 : (g_ovr | (burst & g_done));
        end else if (g_rd) begin
            g_done <= 1'b0;
            g_ovr  <= 1'b0;
        end
    end

    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ch_done[$past(wr_chan)] && g_done));
    // R8
    ovr_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_ovr) |-> $past(burst));
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the conversion sequencer: control and interrupt-enable
// registers, read mux with read-to-clear strobes, interrupt line, and
// the divider, trigger, sequencer and result-bank instances.
// Assumes single-cycle bus strobes and a read data path sampled combinationally.
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NUM_TRIG-1:0] trig_in,
    output logic                conv_clk_en,
    output logic                conv_start,
    output logic [CH_W-1:0]     conv_chan,
    input  logic                conv_busy,
    input  logic                conv_done,
    input  logic [RES_W-1:0]    conv_result,
    output logic                irq
);
    ctrl_t                        ctrl_q;
    logic [NUM_CH:0]              ien_q;
    logic                         ctrl_wr;
    logic                         tick;
    logic                         trig_pend;
    logic                         launch;
    logic                         single_req;
    logic                         wr_en;
    logic [CH_W-1:0]              wr_chan;
    logic [RES_W-1:0]             wr_data;
    logic [NUM_CH-1:0]            ch_rd;
    logic                         g_rd;
    logic [NUM_CH-1:0][RES_W-1:0] ch_res;
    logic [NUM_CH-1:0]            ch_done;
    logic [NUM_CH-1:0]            ch_ovr;
    logic [RES_W-1:0]             g_res;
    logic [CH_W-1:0]              g_chan;
    logic                         g_done;
    logic                         g_ovr;
    logic [CH_W-1:0]              rd_idx;

    assign ctrl_wr    = bus_wr && (bus_addr == REG_CTRL);
    assign single_req = (ctrl_q.start == START_NOW) || trig_pend;
    assign rd_idx     = bus_addr[CH_W-1:0];
    assign conv_clk_en = tick;

    // Control register; a start-now request clears itself on launch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= ctrl_from_word(bus_wdata);
        else if (launch && ctrl_q.start == START_NOW)
            ctrl_q.start <= START_OFF;
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (bus_wr && bus_addr == REG_IRQEN)
            ien_q <= bus_wdata[NUM_CH:0];
    end

    // Read-to-clear strobes for the result words.
    always_comb begin
        ch_rd = '0;
        if (bus_rd && bus_addr[AW-1])
            ch_rd[rd_idx] = 1'b1;
        g_rd = bus_rd && (bus_addr == REG_GLOBAL);
    end

    // Interrupt when any enabled done flag is set.
    always_comb irq = |(ch_done & ien_q[NUM_CH-1:0]) | (g_done & ien_q[NUM_CH]);

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[AW-1]) begin
            bus_rdata = result_word(ch_done[rd_idx], ch_ovr[rd_idx], rd_idx, ch_res[rd_idx]);
        end else begin
            case (bus_addr)
                REG_CTRL:   bus_rdata = ctrl_to_word(ctrl_q);
                REG_GLOBAL: bus_rdata = result_word(g_done, g_ovr, g_chan, g_res);
                REG_IRQEN:  bus_rdata = DW'(ien_q);
                REG_STATUS: bus_rdata = DW'({irq, ch_ovr, ch_done});
                default:    bus_rdata = '0;
            endcase
        end
    end

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl_q.pwr),
        .div  (ctrl_q.div),
        .tick (tick)
    );

    adc_trig_edge #(.NT(NUM_TRIG), .SEL_W(SEL_W)) u_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (trig_in),
        .sel  (ctrl_q.start),
        .fall (ctrl_q.fall_edge),
        .clear(launch),
        .pend (trig_pend)
    );

    adc_scan_seq #(.NCH(NUM_CH), .CHW(CH_W), .RW(RES_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr        (ctrl_q.pwr),
        .burst      (ctrl_q.burst),
        .mask       (ctrl_q.mask),
        .single_req (single_req),
        .tick       (tick),
        .conv_busy  (conv_busy),
        .conv_done  (conv_done),
        .conv_result(conv_result),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .launch     (launch),
        .wr_en      (wr_en),
        .wr_chan    (wr_chan),
        .wr_data    (wr_data)
    );

    adc_result_bank #(.NCH(NUM_CH), .CHW(CH_W), .RW(RES_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .burst  (ctrl_q.burst),
        .wr_en  (wr_en),
        .wr_chan(wr_chan),
        .wr_data(wr_data),
        .ch_rd  (ch_rd),
        .g_rd   (g_rd),
        .ch_res (ch_res),
        .ch_done(ch_done),
        .ch_ovr (ch_ovr),
        .g_res  (g_res),
        .g_chan (g_chan),
        .g_done (g_done),
        .g_ovr  (g_ovr)
    );

    // R3
    start_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && ctrl_q.start == START_NOW && !ctrl_wr) |=> (ctrl_q.start == START_OFF));
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!conv_start && !irq));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  trig_in = '0;
    logic        conv_clk_en, conv_start, irq;
    logic [2:0]  conv_chan;
    logic        stub_busy, stub_done;
    logic [11:0] stub_res;
    logic [2:0]  stub_ch, stub_cnt;
    int          nconv = 0, nstart = 0, ticks = 0, busy_viol = 0;
    int          nchk = 0, nfail = 0;
    logic [2:0]  start_log [16];
    bit          ended = 0;

    always #2 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .conv_clk_en(conv_clk_en), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_busy(stub_busy), .conv_done(stub_done),
        .conv_result(stub_res), .irq(irq)
    );

    // Converter model: busy for five cycles, then one done pulse.
    always @(posedge clk) begin
        stub_done <= 1'b0;
        if (!rst_n) begin
            stub_busy <= 1'b0; stub_cnt <= '0; stub_ch <= '0; stub_res <= '0;
        end else if (conv_start) begin
            stub_busy <= 1'b1; stub_cnt <= 3'd4; stub_ch <= conv_chan;
        end else if (stub_busy) begin
            if (stub_cnt == 0) begin
                stub_busy <= 1'b0;
                stub_done <= 1'b1;
                stub_res  <= {1'b1, stub_ch, 4'b0, nconv[3:0]};
                nconv     <= nconv + 1;
            end else stub_cnt <= stub_cnt - 1'b1;
        end
    end

    // Observe starts, ticks and starts during busy.
    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            if (nstart < 16) start_log[nstart] = conv_chan;
            nstart++;
            if (stub_busy) busy_viol++;
        end
        if (conv_clk_en) ticks++;
    end

    function automatic logic [31:0] cw(input logic [7:0] m, input logic [7:0] d,
                                       input logic b, input logic p,
                                       input logic [2:0] s, input logic f);
        return {4'b0, f, s, 2'b0, p, 4'b0, b, d, m};
    endfunction

    function automatic logic [31:0] rw(input logic dn, input logic ov,
                                       input logic [2:0] ch, input int n);
        logic [3:0] n4;
        n4 = n[3:0];
        return {dn, ov, 3'b0, ch, 8'b0, 1'b1, ch, 4'b0, n4, 4'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_conv(input int target);
        int g = 0;
        while (nconv < target && g < 500) begin @(negedge clk); g++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // {mask, divider, expected channel}
    localparam logic [18:0] VEC [6] = '{
        {8'h01, 8'd0, 3'd0}, {8'h06, 8'd2, 3'd1}, {8'h80, 8'd5, 3'd7},
        {8'hF0, 8'd1, 3'd4}, {8'h28, 8'd7, 3'd3}, {8'hFF, 8'd3, 3'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int n0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(4'd0, d);  check("R1 ctrl", d, 32'h0);
        bus_read(4'd3, d);  check("R1 status", d, 32'h0);
        check("R1 irq/start", {30'b0, irq, conv_start}, 32'h0);

        // R2: divider period and power gating
        bus_write(4'd0, cw(8'h00, 8'd3, 0, 1, 3'd0, 0));
        ticks = 0; repeat (40) @(negedge clk);
        check("R2 ticks div3", ticks, 10);
        bus_write(4'd0, 32'h0);
        ticks = 0; repeat (20) @(negedge clk);
        check("R2 ticks off", ticks, 0);

        // R3 R4 R5: table of single software starts
        for (int i = 0; i < 6; i++) begin
            logic [7:0] m; logic [7:0] dv; logic [2:0] ch;
            m = VEC[i][18:11]; dv = VEC[i][10:3]; ch = VEC[i][2:0];
            n0 = nconv;
            bus_write(4'd0, cw(m, dv, 0, 1, 3'd1, 0));
            wait_conv(n0 + 1);
            bus_read(4'd1, d);             check("R4 global word", d, rw(1, 0, ch, n0));
            bus_read(4'(8 + ch), d);       check("R4 channel word", d, rw(1, 0, ch, n0));
            bus_read(4'(8 + ch), d);       check("R5 done cleared", d, rw(0, 0, ch, n0));
            bus_read(4'd0, d);             check("R3 start self-clear", d, cw(m, dv, 0, 1, 3'd0, 0));
            bus_write(4'd0, 32'h0);
        end

        // R10: no start with power off, request stays
        n0 = nconv;
        bus_write(4'd0, cw(8'h01, 8'd0, 0, 0, 3'd1, 0));
        repeat (30) @(negedge clk);
        check("R10 no conversion", nconv, n0);
        bus_read(4'd0, d); check("R10 start kept", {29'b0, d[26:24]}, 32'd1);
        bus_write(4'd0, 32'h0);

        // R6: falling edge on trig_in[2], rising ignored
        bus_write(4'd0, cw(8'h08, 8'd0, 0, 1, 3'd4, 1));
        n0 = nconv;
        @(negedge clk); trig_in[2] = 1'b1;
        repeat (20) @(negedge clk);
        check("R6 wrong edge ignored", nconv, n0);
        @(negedge clk); trig_in[2] = 1'b0;
        wait_conv(n0 + 1);
        bus_read(4'd11, d); check("R6 falling edge start", d, rw(1, 0, 3'd3, n0));
        // R6: rising edge on trig_in[5]
        bus_write(4'd0, cw(8'h08, 8'd0, 0, 1, 3'd7, 0));
        n0 = nconv;
        @(negedge clk); trig_in[5] = 1'b1;
        wait_conv(n0 + 1);
        bus_read(4'd11, d); check("R6 rising edge start", d, rw(1, 0, 3'd3, n0));
        bus_write(4'd0, 32'h0);
        bus_read(4'd1, d);

        // R7 R8: burst scan over channels 2, 5, 7
        n0 = nconv; nstart = 0;
        bus_write(4'd0, cw(8'hA4, 8'd0, 1, 1, 3'd0, 0));
        while (nstart < 5 && nconv < n0 + 50) @(negedge clk);
        bus_write(4'd0, cw(8'hA4, 8'd0, 0, 1, 3'd0, 0));
        wait_conv(n0 + 5);
        check("R7 scan order",
              {17'b0, start_log[0], start_log[1], start_log[2], start_log[3], start_log[4]},
              {17'b0, 3'd2, 3'd5, 3'd7, 3'd2, 3'd5});
        check("R7 start count", nstart, 5);
        bus_read(4'd3, d); check("R8 status overrun", d, 32'h0000_04A4);

        // R9: interrupt enables
        bus_write(4'd2, 32'h0000_0020);
        check("R9 irq channel enable", {31'b0, irq}, 32'd1);
        bus_read(4'd3, d); check("R9 status irq bit", {31'b0, d[16]}, 32'd1);
        bus_read(4'd13, d);
        check("R9 irq after read", {31'b0, irq}, 32'd0);
        bus_write(4'd2, 32'h0000_0100);
        check("R9 irq global enable", {31'b0, irq}, 32'd1);
        bus_read(4'd1, d);
        check("R9 irq after global read", {31'b0, irq}, 32'd0);
        bus_read(4'd10, d); check("R8 channel overrun flag", {30'b0, d[31:30]}, 32'd3);
        bus_read(4'd3, d);  check("R8 overrun cleared", d, 32'h0000_0080);

        // R11: no start while busy
        check("R11 start during busy", busy_viol, 0);
        finish_run();
    end
endmodule